// File: doc/BRIEF.md
# Single-Bus Register Datapath with Carry-Skip Adder

This block is the register and arithmetic half of a small processor core in which every transfer crosses one shared write bus. Nine registers are kept: an accumulator, a program counter, two adder operand registers, a general buffer, a return-address register, a memory address register, a memory buffer register and one shift-right register selected by address. Each register bit behaves as a set/reset storage cell. A clear strobe forces bits to zero and a write strobe can only force bits to one. A load is therefore a clear followed by a write, or both strobes in one cycle.

An external sequencer drives per-register clear, write and read strobes every cycle. The bus is the bitwise OR of every source whose read strobe is active: registers, the adder sum and an external memory data port. With no source selected the bus is zero. A carry-skip adder forms the sum from the two operand registers without a clock. Subtraction uses a strobe that loads the second operand with the inverted bus value, plus a carry-in. A direct path copies the accumulator into the first operand register without using the bus.

Register index mapping on the strobe vectors is fixed: 0 accumulator, 1 program counter, 2 operand X, 3 operand Y, 4 buffer, 5 return address, 6 memory address, 7 memory buffer, 8 shift-right register.

Top module: `wbus_datapath`

## Requirements
- R1: After the active-low reset every register holds zero, and the bus reads zero when no read strobe is active.
- R2: A register with neither its clear nor its write strobe active keeps its value on every clock edge.
- R3: A write strobe without a clear ORs the bus value into the register, so bits can be set but never cleared.
- R4: A clear strobe alone zeroes the register; clear and write in the same cycle leave exactly the bus value.
- R5: The bus equals the bitwise OR of all sources whose read strobe is active (registers, sum, memory data), and it is zero when none is active.
- R6: sumOut equals (X + Y + carryIn) mod 2^16 and carryOut equals bit 16 of that sum, without a clock, including the all-ones-plus-one case.
- R7: The sum reaches the bus only while the sum read strobe is active.
- R8: The accumulator-to-X strobe replaces X with the accumulator value at the clock edge. If X's write strobe is also active, the bus value is ORed in as well.
- R9: The inverted-operand strobe ORs the complement of the bus into Y, so clearing Y, applying it with value v and asserting carryIn gives sumOut = X - v mod 2^16.
- R10: A write into register 8 stores the bus shifted right by one bit with bit 15 kept (bit 15 of the result equals bus bit 15, bits 14..0 equal bus bits 15..1). Reading register 8 returns that stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clrPulse | input | 9 | Per-register clear strobes (index map above) |
| wrPulse | input | 9 | Per-register write (set) strobes |
| rdPulse | input | 9 | Per-register read-onto-bus strobes |
| rdSum | input | 1 | Place adder sum on the bus |
| rdMem | input | 1 | Place memData on the bus |
| memData | input | 16 | External memory read data |
| a2xPulse | input | 1 | Copy accumulator into X, discarding old X |
| wrYInvPulse | input | 1 | OR the inverted bus into Y |
| carryIn | input | 1 | Adder carry input |
| busOut | output | 16 | Current write-bus value |
| sumOut | output | 16 | Adder sum |
| carryOut | output | 1 | Adder carry out of bit 15 |

## Verification
A register bit stuck at one or lost on a set shows up on busOut in the same cycle that register's read strobe is raised, and the pairwise read sweep separates it from a fault in the bus OR. A wrong carry in any skip block shows on sumOut directly after both operands are loaded, so the sweep includes carries that cross block boundaries and the full-ripple case. Faults in the direct transfer, the inverted load or the shift placement appear one clock after the strobe, when the target register is read back.

// File: rtl/wbus_pkg.sv
package wbus_pkg;
  localparam int NREG = 9;

  localparam int IDX_A   = 0;
  localparam int IDX_Z   = 1;
  localparam int IDX_X   = 2;
  localparam int IDX_Y   = 3;
  localparam int IDX_B   = 4;
  localparam int IDX_Q   = 5;
  localparam int IDX_S   = 6;
  localparam int IDX_G   = 7;
  localparam int IDX_SHR = 8;

  typedef struct packed {
    logic [NREG-1:0] clr;
    logic [NREG-1:0] wr;
    logic [NREG-1:0] rd;
    logic            rdSum;
    logic            rdMem;
    logic            a2x;
    logic            yInv;
    logic            cin;
  } strobes_t;
endpackage

// File: rtl/wbus_srreg.sv
module wbus_srreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic [W-1:0] setVec,
  output logic [W-1:0] q
);
  // clear acts before set inside one edge, so clear+set gives a clean load
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= (q & ~{W{clr}}) | setVec;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clr && setVec == '0) |=> (q == $past(q)));

  p_setonly_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!clr) |=> ((q & $past(q)) == $past(q)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clr && setVec == '0) |=> (q == '0));
endmodule

// File: rtl/wbus_adder.sv
module wbus_adder #(
  parameter int W   = 16,
  parameter int BLK = 4
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NB = W / BLK;

  logic [NB:0] blkCarry;
  assign blkCarry[0] = cin;

  for (genvar g = 0; g < NB; g++) begin : g_blk
    logic [BLK:0]   rip;
    logic [BLK-1:0] prop;
    assign rip[0] = blkCarry[g];
    for (genvar k = 0; k < BLK; k++) begin : g_bit
      assign prop[k]         = opA[g*BLK+k] ^ opB[g*BLK+k];
      assign sum[g*BLK+k]    = prop[k] ^ rip[k];
      assign rip[k+1]        = (opA[g*BLK+k] & opB[g*BLK+k]) | (prop[k] & rip[k]);
    end
    // skip path: a fully propagating block passes its incoming carry straight on
    assign blkCarry[g+1] = (&prop) ? blkCarry[g] : rip[BLK];
  end

  assign cout = blkCarry[NB];
endmodule

// File: rtl/wbus_ctrl.sv
module wbus_ctrl
  import wbus_pkg::*;
(
  input  logic [NREG-1:0] clrPulse,
  input  logic [NREG-1:0] wrPulse,
  input  logic [NREG-1:0] rdPulse,
  input  logic            rdSum,
  input  logic            rdMem,
  input  logic            a2xPulse,
  input  logic            wrYInvPulse,
  input  logic            carryIn,
  output strobes_t        st
);
  always_comb begin
    st       = '0;
    st.clr   = clrPulse;
    st.wr    = wrPulse;
    st.rd    = rdPulse;
    st.rdSum = rdSum;
    st.rdMem = rdMem;
    st.a2x   = a2xPulse;
    st.yInv  = wrYInvPulse;
    st.cin   = carryIn;
    // direct accumulator transfer discards the old X contents
    st.clr[IDX_X] = clrPulse[IDX_X] | a2xPulse;
  end
endmodule

// File: rtl/wbus_dp.sv
module wbus_dp
  import wbus_pkg::*;
#(
  parameter int W   = 16,
  parameter int BLK = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobes_t     st,
  input  logic [W-1:0] memData,
  output logic [W-1:0] busOut,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W-1:0] regQ [NREG];
  logic [W-1:0] setV [NREG];
  logic [W-1:0] busV;
  logic [W-1:0] sumV;
  logic         coutV;

  wbus_adder #(.W(W), .BLK(BLK)) adder_i (
    .opA (regQ[IDX_X]),
    .opB (regQ[IDX_Y]),
    .cin (st.cin),
    .sum (sumV),
    .cout(coutV)
  );

  always_comb begin
    busV = st.rdMem ? memData : '0;
    for (int i = 0; i < NREG; i++) begin
      if (st.rd[i]) busV = busV | regQ[i];
    end
    if (st.rdSum) busV = busV | sumV;
  end

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      setV[i] = st.wr[i] ? busV : '0;
    end
    if (st.a2x)  setV[IDX_X] = setV[IDX_X] | regQ[IDX_A];
    if (st.yInv) setV[IDX_Y] = setV[IDX_Y] | ~busV;
    setV[IDX_SHR] = st.wr[IDX_SHR] ? {busV[W-1], busV[W-1:1]} : '0;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    wbus_srreg #(.W(W)) reg_i (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (st.clr[i]),
      .setVec(setV[i]),
      .q     (regQ[i])
    );
  end

  assign busOut   = busV;
  assign sumOut   = sumV;
  assign carryOut = coutV;

  p_bus_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (st.rd == '0 && !st.rdSum && !st.rdMem) |-> (busV == '0));

  p_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    ({coutV, sumV} == ({1'b0, regQ[IDX_X]} + {1'b0, regQ[IDX_Y]} + {{W{1'b0}}, st.cin})));

  p_a2x_r8: assert property (@(posedge clk) disable iff (!rstN)
    (st.a2x && !st.wr[IDX_X]) |=> (regQ[IDX_X] == $past(regQ[IDX_A])));

  p_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.clr[IDX_SHR] && st.wr[IDX_SHR]) |=>
      (regQ[IDX_SHR][W-2:0] == $past(busV[W-1:1]) && regQ[IDX_SHR][W-1] == $past(busV[W-1])));
endmodule

// File: rtl/wbus_datapath.sv
module wbus_datapath
  import wbus_pkg::*;
#(
  parameter int W   = 16,
  parameter int BLK = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NREG-1:0] clrPulse,
  input  logic [NREG-1:0] wrPulse,
  input  logic [NREG-1:0] rdPulse,
  input  logic            rdSum,
  input  logic            rdMem,
  input  logic [W-1:0]    memData,
  input  logic            a2xPulse,
  input  logic            wrYInvPulse,
  input  logic            carryIn,
  output logic [W-1:0]    busOut,
  output logic [W-1:0]    sumOut,
  output logic            carryOut
);
  strobes_t st;

  wbus_ctrl ctrl_i (
    .clrPulse   (clrPulse),
    .wrPulse    (wrPulse),
    .rdPulse    (rdPulse),
    .rdSum      (rdSum),
    .rdMem      (rdMem),
    .a2xPulse   (a2xPulse),
    .wrYInvPulse(wrYInvPulse),
    .carryIn    (carryIn),
    .st         (st)
  );

  wbus_dp #(.W(W), .BLK(BLK)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .memData (memData),
    .busOut  (busOut),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );
endmodule

// File: tb/wbus_datapath_tb_top.sv
module wbus_datapath_tb_top;
  localparam int NR = 9;
  localparam int RX = 2, RY = 3, RA = 0, RSH = 8;

  logic          clk = 0;
  logic          rstN = 0;
  logic [NR-1:0] clrPulse, wrPulse, rdPulse;
  logic          rdSum, rdMem, a2xPulse, wrYInvPulse, carryIn;
  logic [15:0]   memData, busOut, sumOut;
  logic          carryOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  logic [15:0] model [NR];

  always #5 clk = ~clk;

  wbus_datapath dut_i (
    .clk(clk), .rstN(rstN), .clrPulse(clrPulse), .wrPulse(wrPulse),
    .rdPulse(rdPulse), .rdSum(rdSum), .rdMem(rdMem), .memData(memData),
    .a2xPulse(a2xPulse), .wrYInvPulse(wrYInvPulse), .carryIn(carryIn),
    .busOut(busOut), .sumOut(sumOut), .carryOut(carryOut)
  );

  task automatic idle();
    clrPulse = '0; wrPulse = '0; rdPulse = '0;
    rdSum = 0; rdMem = 0; a2xPulse = 0; wrYInvPulse = 0; carryIn = 0;
    memData = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2; idle();
  endtask

  task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic loadReg(int i, logic [15:0] v);
    clrPulse[i] = 1; wrPulse[i] = 1; rdMem = 1; memData = v;
    tick();
    model[i] = (i == RSH) ? {v[15], v[15:1]} : v;
  endtask

  task automatic readReg(int i, output logic [15:0] v);
    rdPulse = '0; rdPulse[i] = 1; #1; v = busOut; rdPulse = '0; #1;
  endtask

  initial begin
    logic [15:0] v;
    idle();
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #1;
    // R1: reset state
    check("R1 idle bus", {1'b0, busOut}, 17'h0);
    for (int i = 0; i < NR; i++) begin
      readReg(i, v); check("R1 reg zero", {1'b0, v}, 17'h0);
    end
    // R4: combined clear+write loads exactly; R3: write alone ORs in
    loadReg(RA, 16'h0005);
    wrPulse[RA] = 1; rdMem = 1; memData = 16'h0030; tick();
    readReg(RA, v); check("R3 set only", {1'b0, v}, 17'h0035);
    loadReg(RA, 16'hF0F0);
    readReg(RA, v); check("R4 clear+write exact", {1'b0, v}, 17'h0F0F0);
    clrPulse[RA] = 1; tick();
    readReg(RA, v); check("R4 clear alone", {1'b0, v}, 17'h0);
    // R10 shift register
    loadReg(RSH, 16'h8003); readReg(RSH, v); check("R10 shift msb kept", {1'b0, v}, 17'h0C001);
    loadReg(RSH, 16'h0006); readReg(RSH, v); check("R10 shift plain", {1'b0, v}, 17'h0003);
    // R5: load every register, sweep all pairs of reads
    for (int i = 0; i < NR; i++) loadReg(i, (16'h0001 << i) | (16'h8000 >> (i + 1)) | 16'h0100);
    repeat (3) tick();
    for (int i = 0; i < NR; i++) begin
      readReg(i, v); check("R2 hold", {1'b0, v}, {1'b0, model[i]});
    end
    for (int i = 0; i < NR; i++) begin
      for (int j = i + 1; j < NR; j++) begin
        rdPulse[i] = 1; rdPulse[j] = 1; rdMem = 1; memData = 16'h2000; #1;
        check("R5 bus OR", {1'b0, busOut}, {1'b0, model[i] | model[j] | 16'h2000});
        idle(); #1;
      end
    end
    // R6 adder sweep; R7 bus gating of the sum
    for (int n = 0; n < 48; n++) begin
      logic [15:0] a, b; logic c; logic [16:0] e;
      a = 16'(n * 16'h1357 + 16'h0F0F); b = 16'(n * 16'h2468) ^ 16'hF0F1; c = n[0];
      if (n == 0) begin a = 16'hFFFF; b = 16'h0001; c = 0; end
      if (n == 1) begin a = 16'h0FFF; b = 16'h0000; c = 1; end
      if (n == 2) begin a = 16'hFFFF; b = 16'hFFFF; c = 1; end
      loadReg(RX, a); loadReg(RY, b);
      carryIn = c; #1;
      e = {1'b0, a} + {1'b0, b} + {16'h0, c};
      check("R6 sum", {carryOut, sumOut}, e);
      check("R7 sum off bus", {1'b0, busOut}, 17'h0);
      rdSum = 1; #1;
      check("R7 sum on bus", {1'b0, busOut}, {1'b0, e[15:0]});
      idle(); #1;
    end
    // R8 direct accumulator transfer
    loadReg(RA, 16'h1234); loadReg(RX, 16'hFF00);
    a2xPulse = 1; tick();
    readReg(RX, v); check("R8 a2x replaces X", {1'b0, v}, 17'h1234);
    loadReg(RX, 16'hFF00);
    a2xPulse = 1; wrPulse[RX] = 1; rdMem = 1; memData = 16'h0001; tick();
    readReg(RX, v); check("R8 a2x plus bus", {1'b0, v}, 17'h1235);
    // R9 subtraction via inverted operand
    loadReg(RX, 16'd100);
    clrPulse[RY] = 1; wrYInvPulse = 1; rdMem = 1; memData = 16'd30; tick();
    carryIn = 1; #1; check("R9 100-30", {1'b0, sumOut}, 17'd70); idle(); #1;
    loadReg(RX, 16'd30);
    clrPulse[RY] = 1; wrYInvPulse = 1; rdMem = 1; memData = 16'd100; tick();
    carryIn = 1; #1; check("R9 30-100", {1'b0, sumOut}, 17'h0FFBA); idle(); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule